// File: doc/BRIEF.md
# Test Vector Streamer with Loopback Comparator

This block keeps a buffer of byte-wide test vectors in a true dual-port memory. While the block is idle, a simple host port can write and read the buffer through port A. A start pulse hands port A to an internal address counter. The counter then plays the buffer out to the device under test as a byte stream. Each byte carries a valid strobe and a two-bit position code. The stream plays either once or in a loop, up to a programmable last address.

Port B works on its own to rebuild the expected stream. When the receive enable rises, the expected sequence restarts at address zero. Each returned byte sampled while the enable is high is then checked against the buffer, and a mismatch gives a single-cycle error pulse for an external counter. The check assumes that the device under test hands back exactly what it received, as a shifter or FIFO pattern does.

Top module: `vec_stream_cmp`

## Requirements
- R1: While `rst_n` is low and after reset, `tx_en`, `tx_done` and `err_pulse` are 0 and `tx_ctrl` is 00.
- R2: When not streaming, `host_we` writes `host_wdata` at `host_addr`, and `host_rdata` shows the entry at `host_addr` one clock after that address is sampled.
- R3: If `start` is sampled on edge n, `tx_en` is 0 after edge n. After edge n+1+k it is 1, with `tx_data` equal to entry k.
- R4: `tx_ctrl` is 00 when no byte is valid, 01 for the entry at address 0, 11 for the entry at `last_addr` (11 also wins when `last_addr` is 0), and 10 otherwise.
- R5: With `single_pass` high, `tx_done` rises together with the byte from `last_addr`. `tx_en` is 0 from the next cycle on, and `tx_done` stays high until `start` or `halt`.
- R6: With `single_pass` low, the entry at address 0 follows the entry at `last_addr` on the very next cycle.
- R7: `halt` sampled while streaming makes `tx_en` 0 from the next cycle on and returns the block to the load phase. When `start` and `halt` are both high, `halt` wins.
- R8: Host writes presented while streaming leave the buffer unchanged.
- R9: A rising edge of `rx_en` restarts the expected sequence at address 0. Each `rx_data` byte sampled with `rx_en` high is compared with the next expected entry. On a mismatch, `err_pulse` is high for exactly the one cycle that follows that sample edge.
- R10: The expected address wraps to 0 after `last_addr`.
- R11: Bytes sampled with `rx_en` low are ignored, and `err_pulse` is 0 in the cycle after the edge that samples `rx_en` low.
- R12: Streaming on port A and comparing on port B run in the same cycles without interfering with each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe, honoured in load phase only |
| host_addr | input | ADDR_W | Host buffer address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Port A read data, one cycle after the address |
| last_addr | input | ADDR_W | Final address of the vector sequence |
| single_pass | input | 1 | 1: play once and stop; 0: loop |
| start | input | 1 | Begin streaming from address 0 |
| halt | input | 1 | Abort streaming and return to load phase |
| tx_data | output | DATA_W | Outgoing vector byte |
| tx_en | output | 1 | Outgoing byte valid |
| tx_ctrl | output | 2 | Position code of the outgoing byte |
| tx_done | output | 1 | Single pass finished |
| rx_en | input | 1 | Receive enable; rising edge restarts the compare |
| rx_data | input | DATA_W | Returned byte from the device under test |
| err_pulse | output | 1 | One-cycle mismatch indication |

## Verification
Transmit streaming and receive comparison can land in the same cycle. The bench provokes this by looping the sampled `tx_data`/`tx_en` back onto `rx_data`/`rx_en` with one byte corrupted. It then judges that only that byte raises `err_pulse` while the stream keeps its data and codes. A mismatch on the final byte before `rx_en` falls is a second collision. That pulse must still appear, and nothing may follow it in the next cycle.

// File: rtl/vsc_pkg.sv
// Shared types for the test vector streamer.
package vsc_pkg;
    // Position code sent alongside each transmitted byte.
    typedef enum logic [1:0] {
        CTL_IDLE  = 2'b00,
        CTL_FIRST = 2'b01,
        CTL_MID   = 2'b10,
        CTL_LAST  = 2'b11
    } ctl_e;

    // Ownership phase of memory port A.
    typedef enum logic [1:0] {
        PH_LOAD = 2'b00,
        PH_RUN  = 2'b01,
        PH_DONE = 2'b10
    } phase_e;
endpackage

// File: rtl/vsc_dpram.sv
// True dual-port vector memory.
// Port A: read/write with a registered read (old data on a write).
// Port B: read only, registered, enabled by b_re.
// Assumes a single clock for both ports and no contents after reset.
module vsc_dpram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_q,
    input  logic              b_re,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Port A: optional write plus registered read.
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        a_q <= mem[a_addr];
    end

    // Port B: registered read when enabled.
    always_ff @(posedge clk) begin
        if (b_re) b_q <= mem[b_addr];
    end
endmodule

// File: rtl/vsc_tx_seq.sv
// Transmit sequencer. It owns port A while streaming, walks addresses
// 0..last_addr, and produces the byte strobe, position code and done flag.
// It assumes a one-cycle port A read latency, so the strobe and code are
// registered one stage behind the address.
module vsc_tx_seq
    import vsc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              halt,
    input  logic              single_pass,
    input  logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              tx_en,
    output logic [1:0]        tx_ctrl,
    output logic              done
);
    phase_e            phase;
    logic [ADDR_W-1:0] addr;
    ctl_e              code;
    ctl_e              ctl_q;

    // Position code of the address now being read.
    always_comb begin
        if (addr == last_addr)  code = CTL_LAST;
        else if (addr == '0)    code = CTL_FIRST;
        else                    code = CTL_MID;
    end

    // Phase and address sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_LOAD;
            addr  <= '0;
        end else begin
            case (phase)
                PH_RUN: begin
                    if (halt) begin
                        phase <= PH_LOAD;
                    end else if (addr == last_addr) begin
                        addr  <= '0;
                        phase <= single_pass ? PH_DONE : PH_RUN;
                    end else begin
                        addr <= addr + 1'b1;
                    end
                end
                default: begin
                    if (halt) begin
                        phase <= PH_LOAD;
                    end else if (start) begin
                        phase <= PH_RUN;
                        addr  <= '0;
                    end
                end
            endcase
        end
    end

    // Strobe and code aligned with the memory read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            ctl_q <= CTL_IDLE;
        end else begin
            tx_en <= (phase == PH_RUN) && !halt;
            ctl_q <= ((phase == PH_RUN) && !halt) ? code : CTL_IDLE;
        end
    end

    assign rd_addr = addr;
    assign busy    = (phase == PH_RUN);
    assign done    = (phase == PH_DONE);
    assign tx_ctrl = ctl_q;

    p_idle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> tx_ctrl == CTL_IDLE);
    p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start && !halt) |=> done);
    p_halt_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !tx_en);
endmodule

// File: rtl/vsc_rx_cmp.sv
// Receive comparator. On a rising rx_en it restarts the expected address
// at 0 and reads port B for every sampled byte. The returned byte goes
// through one register to match the port B read latency, and a mismatch
// gives a single-cycle error. It assumes the device returns the data
// exactly as sent.
module vsc_rx_cmp #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] exp_q,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              err_pulse
);
    logic              en_d;
    logic              cmp_v;
    logic [DATA_W-1:0] rx_q;
    logic [ADDR_W-1:0] nxt;
    logic              rise;

    assign rise    = rx_en && !en_d;
    assign rd_addr = rise ? '0 : nxt;
    assign rd_en   = rx_en;

    // Edge history, compare-valid stage and next expected address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d  <= 1'b0;
            cmp_v <= 1'b0;
            rx_q  <= '0;
            nxt   <= '0;
        end else begin
            en_d  <= rx_en;
            cmp_v <= rx_en;
            rx_q  <= rx_data;
            if (rx_en) nxt <= (rd_addr == last_addr) ? '0 : rd_addr + 1'b1;
        end
    end

    assign err_pulse = cmp_v && (exp_q != rx_q);

    p_err_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(rx_en));
    p_quiet_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_en) |=> !err_pulse);
endmodule

// File: rtl/vec_stream_cmp.sv
// Top of the test vector streamer and comparator. Port A is muxed between
// the host (load phase) and the transmit sequencer (streaming). Port B
// belongs to the receive comparator. There is one clock domain.
module vec_stream_cmp #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic              single_pass,
    input  logic              start,
    input  logic              halt,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_en,
    output logic [1:0]        tx_ctrl,
    output logic              tx_done,
    input  logic              rx_en,
    input  logic [DATA_W-1:0] rx_data,
    output logic              err_pulse
);
    logic              busy;
    logic [ADDR_W-1:0] tx_addr;
    logic [ADDR_W-1:0] a_addr;
    logic              a_we;
    logic [DATA_W-1:0] a_q;
    logic              b_re;
    logic [ADDR_W-1:0] b_addr;
    logic [DATA_W-1:0] b_q;

    // Port A ownership: the sequencer while streaming, otherwise the host.
    assign a_addr = busy ? tx_addr : host_addr;
    assign a_we   = host_we && !busy;

    vsc_dpram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .a_we    (a_we),
        .a_addr  (a_addr),
        .a_wdata (host_wdata),
        .a_q     (a_q),
        .b_re    (b_re),
        .b_addr  (b_addr),
        .b_q     (b_q)
    );

    vsc_tx_seq #(.ADDR_W(ADDR_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .halt        (halt),
        .single_pass (single_pass),
        .last_addr   (last_addr),
        .rd_addr     (tx_addr),
        .busy        (busy),
        .tx_en       (tx_en),
        .tx_ctrl     (tx_ctrl),
        .done        (tx_done)
    );

    vsc_rx_cmp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .rx_data   (rx_data),
        .last_addr (last_addr),
        .exp_q     (b_q),
        .rd_en     (b_re),
        .rd_addr   (b_addr),
        .err_pulse (err_pulse)
    );

    assign tx_data    = a_q;
    assign host_rdata = a_q;

    p_start_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tx_done && start && !halt) |=> ##1 (tx_en && tx_ctrl != 2'b10));
endmodule

// File: tb/vec_stream_cmp_test.sv
`timescale 1ns/1ps
module vec_stream_cmp_test;
    localparam int DW = 8;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] last_addr = 8'd7;
    logic          single_pass = 1'b1;
    logic          start = 1'b0;
    logic          halt = 1'b0;
    logic [DW-1:0] tx_data;
    logic          tx_en;
    logic [1:0]    tx_ctrl;
    logic          tx_done;
    logic          rx_en = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          err_pulse;

    int n_chk = 0;
    int n_bad = 0;

    // Compare table: {expected error, xor mask on returned byte}; entry i
    // is compared against buffer address i mod 8.
    localparam logic [8:0] CMP_TAB [10] = '{
        {1'b0, 8'h00}, {1'b1, 8'h01}, {1'b0, 8'h00}, {1'b1, 8'h80},
        {1'b0, 8'h00}, {1'b0, 8'h00}, {1'b1, 8'hFF}, {1'b0, 8'h00},
        {1'b1, 8'h10}, {1'b1, 8'h04}
    };

    always #2 clk = ~clk;

    vec_stream_cmp #(.DATA_W(DW), .ADDR_W(AW)) uut (.*);

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    function automatic logic [1:0] exp_code(input int k, input int last);
        if (k == last) return 2'b11;
        if (k == 0) return 2'b01;
        return 2'b10;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        check("R1 tx_en", 8'(tx_en), 8'h0);
        check("R1 tx_ctrl", 8'(tx_ctrl), 8'h0);
        check("R1 tx_done", 8'(tx_done), 8'h0);
        check("R1 err", 8'(err_pulse), 8'h0);
        rst_n = 1'b1;
        tick();
        check("R1 tx_en after release", 8'(tx_en), 8'h0);

        // R2: load and read back
        for (int i = 0; i < 8; i++) begin
            host_we = 1'b1; host_addr = 8'(i); host_wdata = pat(i);
            tick();
        end
        host_we = 1'b0;
        host_addr = 8'd3; tick();
        check("R2 readback 3", host_rdata, pat(3));
        host_addr = 8'd7; tick();
        check("R2 readback 7", host_rdata, pat(7));

        // R3 R4 R5 R8: single pass, with a host write attempted while streaming
        single_pass = 1'b1;
        start = 1'b1; tick(); start = 1'b0;
        check("R3 no byte yet", 8'(tx_en), 8'h0);
        for (int k = 0; k < 8; k++) begin
            if (k == 0) begin host_we = 1'b1; host_addr = 8'd2; host_wdata = 8'hEE; end
            tick();
            host_we = 1'b0;
            check("R3 tx_en", 8'(tx_en), 8'h1);
            check("R3 tx_data", tx_data, pat(k));
            check("R4 tx_ctrl", 8'(tx_ctrl), 8'(exp_code(k, 7)));
            check("R5 done timing", 8'(tx_done), 8'(k == 7));
        end
        tick();
        check("R5 stops", 8'(tx_en), 8'h0);
        check("R4 idle code", 8'(tx_ctrl), 8'h0);
        tick();
        check("R5 done held", 8'(tx_done), 8'h1);
        host_addr = 8'd2; tick();
        check("R8 write ignored", host_rdata, pat(2));

        // R6: continuous wrap, then R7 halt
        single_pass = 1'b0;
        start = 1'b1; tick(); start = 1'b0;
        for (int k = 0; k < 11; k++) begin
            tick();
            check("R6 wrap data", tx_data, pat(k % 8));
            check("R6 wrap code", 8'(tx_ctrl), 8'(exp_code(k % 8, 7)));
            check("R6 no done", 8'(tx_done), 8'h0);
        end
        halt = 1'b1; tick(); halt = 1'b0;
        check("R7 halt stops", 8'(tx_en), 8'h0);
        tick();
        check("R7 stays stopped", 8'(tx_en), 8'h0);
        start = 1'b1; halt = 1'b1; tick(); start = 1'b0; halt = 1'b0;
        tick();
        check("R7 halt beats start", 8'(tx_en), 8'h0);

        // R9 R10: table-driven compare, last entry mismatches then rx_en falls
        rx_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            rx_data = pat(i % 8) ^ CMP_TAB[i][7:0];
            tick();
            check(i >= 8 ? "R10 wrap compare" : "R9 compare", 8'(err_pulse), 8'(CMP_TAB[i][8]));
        end
        rx_en = 1'b0; rx_data = 8'h5A;
        tick();
        check("R11 quiet after fall", 8'(err_pulse), 8'h0);
        tick();
        check("R11 ignored while low", 8'(err_pulse), 8'h0);

        // R9: rising edge restarts the expected sequence at address 0
        rx_en = 1'b1; rx_data = pat(0); tick();
        rx_data = pat(1); tick();
        check("R9 second byte", 8'(err_pulse), 8'h0);
        rx_en = 1'b0; tick();
        rx_en = 1'b1; rx_data = pat(0); tick();
        check("R9 restart at 0", 8'(err_pulse), 8'h0);
        rx_en = 1'b0; tick();

        // R4: one-entry buffer gives the final code
        last_addr = 8'd0; single_pass = 1'b1;
        start = 1'b1; tick(); start = 1'b0;
        tick();
        check("R4 single entry code", 8'(tx_ctrl), 8'h3);
        check("R4 single entry data", tx_data, pat(0));
        tick();
        check("R5 single entry stop", 8'(tx_en), 8'h0);
        last_addr = 8'd7;

        // R12: loopback of the stream into the comparator, byte 5 corrupted
        start = 1'b1; tick(); start = 1'b0;
        for (int k = 0; k < 10; k++) begin
            tick();
            if (k > 0) check("R12 loopback error", 8'(err_pulse), 8'(k - 1 == 5));
            if (k < 8) check("R12 stream intact", tx_data, pat(k));
            rx_en   = tx_en;
            rx_data = tx_data ^ ((k == 5) ? 8'h01 : 8'h00);
        end
        rx_en = 1'b0;

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule